// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and drives two outputs toward a processor: a normal interrupt and a fast interrupt. Each source can be enabled, raised by software and steered to either output. The block also offers sixteen programmable priority slots. Each slot binds one source number to a handler address. The processor reads a vector register to learn which handler to run. That read also raises the current priority level, so a higher-priority slot can preempt the handler in progress but an equal or lower one cannot.

Software uses a simple register bus with a byte address, write data, read data and separate read and write strobes. Read data is registered and appears in the cycle after the read strobe. Any write to the vector register ends service of the most recent level. Nested handlers unwind in the order they were entered. A request that no enabled slot claims is served through a default handler address at the lowest priority.

Top module: `vec_prio_intc`

## Requirements
- R1: Writing ones to the enable-set register (0x010) sets those mask bits, and writing ones to the enable-clear register (0x014) clears them. Zero bits have no effect in either register. A read of 0x010 returns the mask.
- R2: The software-request register has a set address (0x018), a clear address (0x01C) and the same write-one rules. A read of 0x018 returns it, and software bits are ORed with the request lines before the enable mask is applied.
- R3: `fiqOut` is high one cycle after any source is enabled, requesting and has its bit set in the select register (0x008).
- R4: `irqOut` is high one cycle after an enabled, requesting source with a clear select bit is not masked by the current priority level.
- R5: The slot control register at 0x200+4*i holds an enable flag in bit 5 and a source number in bits 4:0. The slot's handler address is at 0x100+4*i. A read of the vector register (0x000) returns the handler address of the lowest-numbered enabled slot whose source is pending and unmasked. Slot 0 has the highest priority.
- R6: A vector read that selects slot i raises the level to i. Slots i and above are then masked, while slots below i can still interrupt.
- R7: Any write to 0x000 ends the most recently entered level and restores the level in force before it. Writes made with nothing in service change nothing.
- R8: When no slot qualifies, a vector read returns the default address (0x004). It enters the default level only if nothing is in service. Requests not claimed by any enabled slot are masked while any level is in service.
- R9: The byte reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the bytes of the 32-bit cell ID in bits 7:0, least significant byte first.
- R10: After reset, the enable mask, software requests, select bits, slot controls and priority levels are all zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| irqLines | input | 32 | Level request lines |
| irqOut | output | 1 | Normal interrupt |
| fiqOut | output | 1 | Fast interrupt |

## Verification
A table of request, enable, select and software patterns checks the two outputs. The patterns separate masking from steering and show that software bits merge with the request lines. Directed sequences then program two slots and a default address. They nest a higher slot over a lower one, unwind with end-of-service writes, including a surplus write, and mix a slotted request with an unclaimed one. This shows whether levels are pushed and popped in stack order and whether the default level is entered only from idle.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  typedef enum logic [3:0] {
    RD_NONE, RD_ZERO, RD_VEC, RD_DEF, RD_SEL, RD_EN, RD_SW, RD_ADDR, RD_CTL, RD_ID
  } rdKind_e;

  typedef struct packed {
    logic    enSet;
    logic    enClr;
    logic    swSet;
    logic    swClr;
    logic    selWr;
    logic    defWr;
    logic    addrWr;
    logic    ctlWr;
    logic    vecWr;
    rdKind_e rdKind;
    logic [1:0] idByte;
  } busStb_t;

  localparam logic [7:0] OFS_VECT  = 8'h00;
  localparam logic [7:0] OFS_DEF   = 8'h04;
  localparam logic [7:0] OFS_SEL   = 8'h08;
  localparam logic [7:0] OFS_ENSET = 8'h10;
  localparam logic [7:0] OFS_ENCLR = 8'h14;
  localparam logic [7:0] OFS_SWSET = 8'h18;
  localparam logic [7:0] OFS_SWCLR = 8'h1C;

endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int SRC_N = 32,
  parameter int SLOT_N = 16,
  parameter logic [31:0] CELL_ID = 32'hB105_A3C7,
  localparam int SRC_W = $clog2(SRC_N),
  localparam int SLOT_W = $clog2(SLOT_N)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  busStb_t                        stb,
  input  logic [SLOT_W-1:0]              slotIdx,
  input  logic [31:0]                    wdata,
  input  logic [SRC_N-1:0]               hwReq,
  input  logic [31:0]                    vecValue,
  output logic [SRC_N-1:0]               reqAll,
  output logic [SRC_N-1:0]               selMask,
  output logic [SLOT_N-1:0]              slotEn,
  output logic [SLOT_N-1:0][SRC_W-1:0]   slotSrc,
  output logic [SLOT_N-1:0][31:0]        slotAddr,
  output logic [31:0]                    defAddr,
  output logic [31:0]                    rdData
);

  logic [SRC_N-1:0] enMask;
  logic [SRC_N-1:0] softReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask  <= '0;
      softReq <= '0;
      selMask <= '0;
      defAddr <= '0;
    end else begin
      if (stb.enSet)      enMask <= enMask | wdata[SRC_N-1:0];
      else if (stb.enClr) enMask <= enMask & ~wdata[SRC_N-1:0];
      if (stb.swSet)      softReq <= softReq | wdata[SRC_N-1:0];
      else if (stb.swClr) softReq <= softReq & ~wdata[SRC_N-1:0];
      if (stb.selWr)      selMask <= wdata[SRC_N-1:0];
      if (stb.defWr)      defAddr <= wdata;
    end
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddr[g] <= '0;
        slotEn[g]   <= 1'b0;
        slotSrc[g]  <= '0;
      end else begin
        if (stb.addrWr && slotIdx == SLOT_W'(g)) slotAddr[g] <= wdata;
        if (stb.ctlWr && slotIdx == SLOT_W'(g)) begin
          slotEn[g]  <= wdata[SRC_W];
          slotSrc[g] <= wdata[SRC_W-1:0];
        end
      end
    end
  end

  assign reqAll = (hwReq | softReq) & enMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      unique case (stb.rdKind)
        RD_NONE: rdData <= rdData;
        RD_ZERO: rdData <= '0;
        RD_VEC:  rdData <= vecValue;
        RD_DEF:  rdData <= defAddr;
        RD_SEL:  rdData <= 32'(selMask);
        RD_EN:   rdData <= 32'(enMask);
        RD_SW:   rdData <= 32'(softReq);
        RD_ADDR: rdData <= slotAddr[slotIdx];
        RD_CTL:  rdData <= 32'({slotEn[slotIdx], slotSrc[slotIdx]});
        RD_ID:   rdData <= 32'(CELL_ID[8*stb.idByte +: 8]);
        default: rdData <= '0;
      endcase
    end
  end

  a_r1_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> ((enMask & $past(wdata[SRC_N-1:0])) == $past(wdata[SRC_N-1:0])));
  a_r1_clr_drops: assert property (@(posedge clk) disable iff (!rstN)
    stb.enClr |=> ((enMask & $past(wdata[SRC_N-1:0])) == '0));
  a_r2_sw_clr_drops: assert property (@(posedge clk) disable iff (!rstN)
    stb.swClr |=> ((softReq & $past(wdata[SRC_N-1:0])) == '0));

endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int SRC_N = 32,
  parameter int SLOT_N = 16,
  parameter int ADDR_W = 12,
  localparam int SRC_W = $clog2(SRC_N),
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int LVL_N = SLOT_N + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [SRC_N-1:0]               reqAll,
  input  logic [SRC_N-1:0]               selMask,
  input  logic [SLOT_N-1:0]              slotEn,
  input  logic [SLOT_N-1:0][SRC_W-1:0]   slotSrc,
  input  logic [SLOT_N-1:0][31:0]        slotAddr,
  input  logic [31:0]                    defAddr,
  output busStb_t                        stb,
  output logic [SLOT_W-1:0]              slotIdx,
  output logic [31:0]                    vecValue,
  output logic                           irqOut,
  output logic                           fiqOut
);

  localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(12'hFE0);
  localparam logic [ADDR_W-9:0] PAGE_REG  = '0;
  localparam logic [ADDR_W-9:0] PAGE_ADDR = (ADDR_W-8)'(1);
  localparam logic [ADDR_W-9:0] PAGE_CTL  = (ADDR_W-8)'(2);
  localparam logic [LVL_N-1:0]  DEF_LVL   = LVL_N'(1) << SLOT_N;

  // ---------------- bus decode ----------------
  logic [ADDR_W-9:0] page;
  logic [7:0]        off;
  logic              slotOk;
  rdKind_e           kind;

  always_comb begin
    page    = addr[ADDR_W-1:8];
    off     = addr[7:0];
    slotOk  = (addr[7:2] < 6'(SLOT_N));
    slotIdx = addr[2 +: SLOT_W];
    stb     = '0;
    stb.idByte = addr[3:2];
    kind    = RD_ZERO;
    if (addr[1:0] == 2'b00) begin
      if (page == PAGE_REG) begin
        unique case (off)
          OFS_VECT:  begin stb.vecWr = wrEn; kind = RD_VEC; end
          OFS_DEF:   begin stb.defWr = wrEn; kind = RD_DEF; end
          OFS_SEL:   begin stb.selWr = wrEn; kind = RD_SEL; end
          OFS_ENSET: begin stb.enSet = wrEn; kind = RD_EN;  end
          OFS_ENCLR: stb.enClr = wrEn;
          OFS_SWSET: begin stb.swSet = wrEn; kind = RD_SW;  end
          OFS_SWCLR: stb.swClr = wrEn;
          default:   kind = RD_ZERO;
        endcase
      end else if (page == PAGE_ADDR && slotOk) begin
        stb.addrWr = wrEn;
        kind = RD_ADDR;
      end else if (page == PAGE_CTL && slotOk) begin
        stb.ctlWr = wrEn;
        kind = RD_CTL;
      end else if (addr[ADDR_W-1:4] == ID_BASE[ADDR_W-1:4]) begin
        kind = RD_ID;
      end
    end
    stb.rdKind = rdEn ? kind : RD_NONE;
  end

  // ---------------- priority resolution ----------------
  logic [LVL_N-1:0]  inService;
  logic [SRC_N-1:0]  reqNorm, coverage, unslotted;
  logic [SLOT_N-1:0] eligible;
  logic              anyWin, acc, rdVec, irqNext, fiqNext;
  logic [SLOT_W-1:0] winIdx;

  always_comb begin
    reqNorm  = reqAll & ~selMask;
    coverage = '0;
    eligible = '0;
    acc      = 1'b0;
    for (int i = 0; i < SLOT_N; i++) begin
      acc = acc | inService[i];
      eligible[i] = slotEn[i] & reqNorm[slotSrc[i]] & ~acc;
      if (slotEn[i]) coverage[slotSrc[i]] = 1'b1;
    end
    anyWin = 1'b0;
    winIdx = '0;
    for (int i = SLOT_N - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        anyWin = 1'b1;
        winIdx = SLOT_W'(i);
      end
    end
    unslotted = reqNorm & ~coverage;
    vecValue  = anyWin ? slotAddr[winIdx] : defAddr;
    irqNext   = (|eligible) | ((|unslotted) & (inService == '0));
    fiqNext   = |(reqAll & selMask);
    rdVec     = (stb.rdKind == RD_VEC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inService <= '0;
      irqOut    <= 1'b0;
      fiqOut    <= 1'b0;
    end else begin
      irqOut <= irqNext;
      fiqOut <= fiqNext;
      if (rdVec) begin
        if (anyWin)                 inService <= inService | (LVL_N'(1) << winIdx);
        else if (inService == '0)   inService <= DEF_LVL;
      end else if (stb.vecWr) begin
        inService <= inService & (inService - 1'b1);
      end
    end
  end

  a_r6_push_level: assert property (@(posedge clk) disable iff (!rstN)
    (rdVec && anyWin) |=> inService[$past(winIdx)]);
  a_r7_pop_one: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecWr && !rdVec && inService != '0) |=>
      ($countones(inService) == $countones($past(inService)) - 1));
  a_r7_idle_eos: assert property (@(posedge clk) disable iff (!rstN)
    (stb.vecWr && !rdVec && inService == '0) |=> (inService == '0));
  a_r8_no_nested_default: assert property (@(posedge clk) disable iff (!rstN)
    (rdVec && !anyWin && inService != '0) |=> $stable(inService));
  a_r4_irq_has_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|reqNorm));
  a_r3_fiq_has_select: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> $past(|(reqAll & selMask)));

endmodule

// File: rtl/vec_prio_intc.sv
module vec_prio_intc
  import vpic_pkg::*;
#(
  parameter int SRC_N = 32,
  parameter int SLOT_N = 16,
  parameter int ADDR_W = 12,
  parameter logic [31:0] CELL_ID = 32'hB105_A3C7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  input  logic [SRC_N-1:0]  irqLines,
  output logic              irqOut,
  output logic              fiqOut
);

  localparam int SRC_W = $clog2(SRC_N);
  localparam int SLOT_W = $clog2(SLOT_N);

  busStb_t                       stb;
  logic [SLOT_W-1:0]             slotIdx;
  logic [31:0]                   vecValue;
  logic [SRC_N-1:0]              reqAll, selMask;
  logic [SLOT_N-1:0]             slotEn;
  logic [SLOT_N-1:0][SRC_W-1:0]  slotSrc;
  logic [SLOT_N-1:0][31:0]       slotAddr;
  logic [31:0]                   defAddr;

  vpic_ctrl #(.SRC_N(SRC_N), .SLOT_N(SLOT_N), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wrEn(busWrEn), .rdEn(busRdEn),
    .reqAll(reqAll), .selMask(selMask), .slotEn(slotEn), .slotSrc(slotSrc),
    .slotAddr(slotAddr), .defAddr(defAddr), .stb(stb), .slotIdx(slotIdx),
    .vecValue(vecValue), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  vpic_regs #(.SRC_N(SRC_N), .SLOT_N(SLOT_N), .CELL_ID(CELL_ID)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .slotIdx(slotIdx), .wdata(busWrData),
    .hwReq(irqLines), .vecValue(vecValue), .reqAll(reqAll), .selMask(selMask),
    .slotEn(slotEn), .slotSrc(slotSrc), .slotAddr(slotAddr), .defAddr(defAddr),
    .rdData(busRdData)
  );

endmodule

// File: tb/vec_prio_intc_bench.sv
`timescale 1ns/1ps
module vec_prio_intc_bench;

  typedef struct packed {
    logic [31:0] hw;
    logic [31:0] en;
    logic [31:0] sel;
    logic [31:0] sw;
    logic        expIrq;
    logic        expFiq;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TABLE [NV] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0,          32'h0,          1'b1, 1'b0},
    '{32'h0000_0001, 32'h0000_0000, 32'h0,          32'h0,          1'b0, 1'b0},
    '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000,  32'h0,          1'b0, 1'b1},
    '{32'h0000_0000, 32'h0000_0010, 32'h0,          32'h0000_0010,  1'b1, 1'b0},
    '{32'h0000_0003, 32'h0000_0003, 32'h0000_0001,  32'h0,          1'b1, 1'b1},
    '{32'h0000_00F0, 32'h0000_000F, 32'h0,          32'h0,          1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [31:0] irqLines = '0;
  logic        irqOut, fiqOut;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  vec_prio_intc u_vec_prio_intc (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .irqLines(irqLines), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    // R10 reset state
    chk("R10 irq", 32'(irqOut), 0);
    chk("R10 fiq", 32'(fiqOut), 0);
    rd(12'h010, d); chk("R10 enable", d, 0);
    rd(12'h018, d); chk("R10 soft", d, 0);
    rd(12'h008, d); chk("R10 select", d, 0);
    rd(12'h200, d); chk("R10 slot0 ctl", d, 0);

    // R1 set/clear with zero bits ignored
    wr(12'h010, 32'h5); rd(12'h010, d); chk("R1 set", d, 32'h5);
    wr(12'h010, 32'h0); rd(12'h010, d); chk("R1 zero set", d, 32'h5);
    wr(12'h014, 32'h4); rd(12'h010, d); chk("R1 clear", d, 32'h1);
    wr(12'h014, 32'h0); rd(12'h010, d); chk("R1 zero clear", d, 32'h1);
    // R2 soft set/clear
    wr(12'h018, 32'hA0); wr(12'h01C, 32'h20); rd(12'h018, d); chk("R2 soft", d, 32'h80);
    wr(12'h01C, 32'h0); rd(12'h018, d); chk("R2 zero clear", d, 32'h80);

    // table: R3 R4 R2 masking and steering
    for (int k = 0; k < NV; k++) begin
      wr(12'h014, 32'hFFFF_FFFF);
      wr(12'h01C, 32'hFFFF_FFFF);
      wr(12'h010, TABLE[k].en);
      wr(12'h008, TABLE[k].sel);
      wr(12'h018, TABLE[k].sw);
      irqLines = TABLE[k].hw;
      settle();
      chk($sformatf("R4 table irq %0d", k), 32'(irqOut), 32'(TABLE[k].expIrq));
      chk($sformatf("R3 table fiq %0d", k), 32'(fiqOut), 32'(TABLE[k].expFiq));
    end

    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h008, 32'h0);
    irqLines = '0;

    // slots: slot2 <- src4, slot5 <- src7
    wr(12'h208, 32'h24); wr(12'h108, 32'h2000);
    wr(12'h214, 32'h27); wr(12'h114, 32'h5000);
    wr(12'h004, 32'hDEF0);
    wr(12'h010, 32'h290);
    rd(12'h214, d); chk("R5 ctl readback", d, 32'h27);
    irqLines = 32'h80; settle();
    chk("R4 slot irq", 32'(irqOut), 1);
    rd(12'h000, d); chk("R5 vec slot5", d, 32'h5000);
    settle(); chk("R6 masked after push", 32'(irqOut), 0);
    irqLines = 32'h90; settle();
    chk("R6 higher preempts", 32'(irqOut), 1);
    rd(12'h000, d); chk("R5 vec slot2", d, 32'h2000);
    settle(); chk("R6 nested mask", 32'(irqOut), 0);
    wr(12'h000, 0); settle();
    chk("R7 pop to slot5 level", 32'(irqOut), 1);
    irqLines = 32'h80; settle();
    chk("R6 slot5 still masked", 32'(irqOut), 0);
    wr(12'h000, 0); settle();
    chk("R7 pop to idle", 32'(irqOut), 1);
    wr(12'h000, 0); wr(12'h000, 0); settle();
    chk("R7 surplus eos", 32'(irqOut), 1);
    rd(12'h000, d); chk("R7 vec after surplus", d, 32'h5000);
    wr(12'h000, 0);

    // R8 default path
    irqLines = 32'h200; settle();
    chk("R8 unslotted irq", 32'(irqOut), 1);
    rd(12'h000, d); chk("R8 default vec", d, 32'hDEF0);
    settle(); chk("R8 default level masks", 32'(irqOut), 0);
    wr(12'h000, 0); settle();
    chk("R8 default eos", 32'(irqOut), 1);
    irqLines = 32'h280; settle();
    rd(12'h000, d); chk("R8 slot wins over default", d, 32'h5000);
    settle(); chk("R8 unslotted masked by slot", 32'(irqOut), 0);
    rd(12'h000, d); chk("R8 default while busy", d, 32'hDEF0);
    wr(12'h000, 0); settle();
    chk("R8 single pop to idle", 32'(irqOut), 1);
    irqLines = '0;

    // R9 identification bytes
    rd(12'hFE0, d); chk("R9 id0", d, 32'hC7);
    rd(12'hFE4, d); chk("R9 id1", d, 32'hA3);
    rd(12'hFE8, d); chk("R9 id2", d, 32'h05);
    rd(12'hFEC, d); chk("R9 id3", d, 32'hB1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule